// File: doc/BRIEF.md
# ASID-Invalidating Translation Buffer

This block is a small fully associative translation buffer for a paged memory-management unit. Every slot maps one pair of adjacent 4 KB virtual pages to two physical frame numbers. It also holds a global flag, an 8-bit address-space identifier, and execute-inhibit and read-inhibit bits for each half. Software loads one slot at a time through a write port. The port takes a slot number, a high word (virtual page pair, identifier and a "load as invalid" flag) and two low words, one per half. A combinational lookup port takes a virtual page number and the current identifier. It returns hit, slot number, frame number and the inhibit bits of the half picked by the lowest page bit.

Two bulk commands clear slot validity in one clock edge. The per-identifier command drops every non-global slot tagged with the given identifier and ignores the virtual page. The flush command drops every slot. A fixed feature word advertises the invalidation capability at bit 29.

The block has no sequencer. Each clock edge applies one command, decoded with this priority: slot write, then flush, then per-identifier clear, then idle. The flush command outranks the per-identifier command when both are raised. For the written slot the write always wins.

Top module: `tlb_asid_inv`

## Requirements
- R1: After reset no lookup hits, whatever the page or identifier presented.
- R2: A write with `wr_hi[10]`=0 stores the slot. The high word holds the page pair in bits 31:13 and the identifier in bits 7:0. Each low word holds the frame number in bits 25:6. From the next cycle a lookup with `lk_vpn[19:1]` equal to the stored page pair reports that slot.
- R3: A slot is global when bit 0 of both low words is 1. A global slot hits for any `lk_asid`. A non-global slot hits only when `lk_asid` equals its identifier.
- R4: A write with `wr_hi[10]`=1 leaves the slot invalid, so it never hits.
- R5: `inv_asid_req` invalidates every non-global slot whose identifier equals `inv_asid`, whatever its page. A lookup in the next cycle misses it.
- R6: `inv_asid_req` leaves global slots and slots of other identifiers valid.
- R7: `inv_all_req` invalidates every slot, global or not, by the next cycle.
- R8: When a write coincides with either bulk command, the written slot takes the write's result.
- R9: When several slots match, the lowest slot number is reported.
- R10: `feat_word` reads 32'h2000_0000, with only bit 29 (invalidation present) set.
- R11: `lk_vpn[0]`=0 selects the even half (`wr_lo0`) and 1 selects the odd half (`wr_lo1`). The selected half supplies `lk_pfn`, `lk_xi` (low word bit 31) and `lk_ri` (low word bit 30).
- R12: On a miss, `lk_idx`, `lk_pfn`, `lk_xi` and `lk_ri` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write slot strobe |
| wr_idx | input | 4 | Slot number to write |
| wr_hi | input | 32 | High word: page pair, invalid flag, identifier |
| wr_lo0 | input | 32 | Even-half low word |
| wr_lo1 | input | 32 | Odd-half low word |
| inv_asid_req | input | 1 | Invalidate-by-identifier strobe |
| inv_all_req | input | 1 | Flush strobe |
| inv_asid | input | 8 | Identifier for the per-identifier command |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current identifier for lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Matching slot number |
| lk_pfn | output | 20 | Frame number of selected half |
| lk_xi | output | 1 | Execute-inhibit of selected half |
| lk_ri | output | 1 | Read-inhibit of selected half |
| feat_word | output | 32 | Feature word, bit 29 set |

## Verification
The hardest case is a write and a bulk command landing on the same edge, with the written slot tagged with the very identifier being cleared. Other slots carry that identifier too, and some are global. The bench fills all slots with a mix of four identifiers and periodic global slots. It then issues a write into such a slot on the same cycle as the command. A full sweep over every slot, both halves and every identifier then checks survivors and casualties against a bench-side model.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
    localparam int VPN_W       = 20;
    localparam int ASID_W      = 8;
    localparam int PFN_W       = 20;
    localparam int WORD_W      = 32;
    localparam int HI_VPN2_LSB = 13;
    localparam int HI_INV_BIT  = 10;
    localparam int LO_G_BIT    = 0;
    localparam int LO_PFN_LSB  = 6;
    localparam int LO_RI_BIT   = 30;
    localparam int LO_XI_BIT   = 31;
    localparam int FEAT_INV_BIT = 29;

    typedef struct packed {
        logic [VPN_W-2:0]  vpn2;
        logic [ASID_W-1:0] asid;
        logic              g;
        logic [PFN_W-1:0]  pfn0;
        logic [PFN_W-1:0]  pfn1;
        logic              xi0;
        logic              xi1;
        logic              ri0;
        logic              ri1;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_WRITE,
        CMD_INV_ASID,
        CMD_FLUSH
    } slot_cmd_e;

    function automatic tlb_ent_t unpack_words(
        input logic [WORD_W-1:0] hi,
        input logic [WORD_W-1:0] lo0,
        input logic [WORD_W-1:0] lo1
    );
        tlb_ent_t e;
        e.vpn2 = hi[WORD_W-1:HI_VPN2_LSB];
        e.asid = hi[ASID_W-1:0];
        e.g    = lo0[LO_G_BIT] & lo1[LO_G_BIT];
        e.pfn0 = lo0[LO_PFN_LSB +: PFN_W];
        e.pfn1 = lo1[LO_PFN_LSB +: PFN_W];
        e.xi0  = lo0[LO_XI_BIT];
        e.xi1  = lo1[LO_XI_BIT];
        e.ri0  = lo0[LO_RI_BIT];
        e.ri1  = lo1[LO_RI_BIT];
        return e;
    endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_asid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_cmd_e         cmd,
    input  tlb_ent_t          wr_ent,
    input  logic              wr_inv,
    input  logic [ASID_W-1:0] cmd_asid,
    output tlb_ent_t          ent,
    output logic              valid
);
    logic valid_nxt;

    always_comb begin
        valid_nxt = valid;
        unique case (cmd)
            CMD_IDLE:     valid_nxt = valid;
            CMD_WRITE:    valid_nxt = !wr_inv;
            CMD_INV_ASID: if (!ent.g && ent.asid == cmd_asid) valid_nxt = 1'b0;
            CMD_FLUSH:    valid_nxt = 1'b0;
            default:      valid_nxt = valid;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ent   <= '0;
        end else begin
            valid <= valid_nxt;
            if (cmd == CMD_WRITE) ent <= wr_ent;
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_asid_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  tlb_ent_t           ents [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [PFN_W-1:0]   pfn,
    output logic               xi,
    output logic               ri
);
    logic [ENTRIES-1:0] match;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
        assign match[gi] = valid[gi]
                         && ents[gi].vpn2 == lk_vpn[VPN_W-1:1]
                         && (ents[gi].g || ents[gi].asid == lk_asid);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        hit = |match;
        pfn = '0;
        xi  = 1'b0;
        ri  = 1'b0;
        if (hit) begin
            pfn = lk_vpn[0] ? ents[idx].pfn1 : ents[idx].pfn0;
            xi  = lk_vpn[0] ? ents[idx].xi1  : ents[idx].xi0;
            ri  = lk_vpn[0] ? ents[idx].ri1  : ents[idx].ri0;
        end
    end
endmodule

// File: rtl/tlb_asid_inv.sv
module tlb_asid_inv
    import tlb_asid_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_hi,
    input  logic [WORD_W-1:0] wr_lo0,
    input  logic [WORD_W-1:0] wr_lo1,
    input  logic              inv_asid_req,
    input  logic              inv_all_req,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_xi,
    output logic              lk_ri,
    output logic [WORD_W-1:0] feat_word
);
    tlb_ent_t           wr_ent;
    tlb_ent_t           ents [ENTRIES];
    logic [ENTRIES-1:0] valid;
    slot_cmd_e          bulk_cmd;
    logic               unused_bits;

    assign wr_ent      = unpack_words(wr_hi, wr_lo0, wr_lo1);
    assign unused_bits = ^{wr_hi[12:11], wr_hi[9:8], wr_lo0[29:26], wr_lo0[5:1],
                           wr_lo1[29:26], wr_lo1[5:1]};

    always_comb begin
        feat_word = '0;
        feat_word[FEAT_INV_BIT] = 1'b1;
    end

    always_comb begin
        if (inv_all_req)       bulk_cmd = CMD_FLUSH;
        else if (inv_asid_req) bulk_cmd = CMD_INV_ASID;
        else                   bulk_cmd = CMD_IDLE;
    end

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        slot_cmd_e slot_cmd;
        assign slot_cmd = (wr_en && wr_idx == IDX_W'(gi)) ? CMD_WRITE : bulk_cmd;

        tlb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (slot_cmd),
            .wr_ent   (wr_ent),
            .wr_inv   (wr_hi[HI_INV_BIT]),
            .cmd_asid (inv_asid),
            .ent      (ents[gi]),
            .valid    (valid[gi])
        );
    end

    tlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
        .ents    (ents),
        .valid   (valid),
        .lk_vpn  (lk_vpn),
        .lk_asid (lk_asid),
        .hit     (lk_hit),
        .idx     (lk_idx),
        .pfn     (lk_pfn),
        .xi      (lk_xi),
        .ri      (lk_ri)
    );
endmodule

// File: rtl/tlb_asid_inv_chk.sv
module tlb_asid_inv_chk
    import tlb_asid_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [WORD_W-1:0] wr_hi,
    input logic              inv_all_req,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic              lk_xi,
    input logic              lk_ri
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R2
    write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi[HI_INV_BIT]) |=>
        (!(lk_vpn[VPN_W-1:1] == $past(wr_hi[WORD_W-1:HI_VPN2_LSB])
           && lk_asid == $past(wr_hi[ASID_W-1:0])) || lk_hit));

    // R4
    load_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi[HI_INV_BIT]) |=> !(lk_hit && lk_idx == $past(wr_idx)));

    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all_req && !wr_en) |=> !lk_hit);

    // R12
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_idx == '0 && lk_pfn == '0 && !lk_xi && !lk_ri));
endmodule

bind tlb_asid_inv tlb_asid_inv_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tb_tlb_asid_inv.sv
module tb_tlb_asid_inv;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_hi = '0, wr_lo0 = '0, wr_lo1 = '0;
    logic        inv_asid_req = 1'b0, inv_all_req = 1'b0;
    logic [7:0]  inv_asid = '0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_xi, lk_ri;
    logic [3:0]  lk_idx;
    logic [19:0] lk_pfn;
    logic [31:0] feat_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side expected state
    bit          mv    [N];
    logic [18:0] mvpn2 [N];
    logic [7:0]  masid [N];
    bit          mg    [N];
    logic [19:0] mpfn0 [N], mpfn1 [N];
    bit          mx0 [N], mx1 [N], mr0 [N], mr1 [N];

    // staged write fields
    logic [3:0]  s_idx;
    logic [18:0] s_vpn2;
    logic [7:0]  s_asid;
    bit          s_g, s_inv, s_x0, s_x1, s_r0, s_r1;
    logic [19:0] s_p0, s_p1;

    always #5 clk = ~clk;

    tlb_asid_inv dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [26:0] model_lookup(input logic [19:0] vpn, input logic [7:0] asid);
        for (int i = 0; i < N; i++) begin
            if (mv[i] && mvpn2[i] == vpn[19:1] && (mg[i] || masid[i] == asid))
                return {1'b1, 4'(i), vpn[0] ? mpfn1[i] : mpfn0[i],
                        vpn[0] ? mx1[i] : mx0[i], vpn[0] ? mr1[i] : mr0[i]};
        end
        return '0;
    endfunction

    task automatic look(input string req, input logic [19:0] vpn, input logic [7:0] asid);
        @(negedge clk);
        lk_vpn = vpn;
        lk_asid = asid;
        #1;
        check(req, {5'b0, lk_hit, lk_idx, lk_pfn, lk_xi, lk_ri}, {5'b0, model_lookup(vpn, asid)});
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < N; i++)
            for (int h = 0; h < 2; h++)
                for (int a = 0; a < 4; a++)
                    look(req, {mvpn2[i], 1'(h)}, 8'(a));
    endtask

    task automatic stage(input int idx, input int vpn2, input int asid, input bit g, input bit inv);
        s_idx = 4'(idx); s_vpn2 = 19'(vpn2); s_asid = 8'(asid); s_g = g; s_inv = inv;
        s_p0 = 20'(32'h1000 + idx * 2); s_p1 = 20'(32'h1001 + idx * 2);
        s_x0 = idx[0]; s_r0 = idx[1]; s_x1 = idx[2]; s_r1 = idx[3];
    endtask

    // one clock edge carrying any mix of write, per-identifier clear and flush
    task automatic step(input bit w, input bit ia, input bit all, input logic [7:0] a);
        @(negedge clk);
        wr_en = w; wr_idx = s_idx;
        wr_hi  = {s_vpn2, 2'b0, s_inv, 2'b0, s_asid};
        wr_lo0 = {s_x0, s_r0, 4'b0, s_p0, 5'b0, s_g};
        wr_lo1 = {s_x1, s_r1, 4'b0, s_p1, 5'b0, s_g};
        inv_asid_req = ia; inv_all_req = all; inv_asid = a;
        for (int i = 0; i < N; i++) begin
            if (w && i == int'(s_idx)) begin
                mv[i] = !s_inv; mvpn2[i] = s_vpn2; masid[i] = s_asid; mg[i] = s_g;
                mpfn0[i] = s_p0; mpfn1[i] = s_p1;
                mx0[i] = s_x0; mx1[i] = s_x1; mr0[i] = s_r0; mr1[i] = s_r1;
            end else if (all) mv[i] = 0;
            else if (ia && !mg[i] && masid[i] == a) mv[i] = 0;
        end
        @(negedge clk);
        wr_en = 0; inv_asid_req = 0; inv_all_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mvpn2[i] = 19'(i * 3 + 1); masid[i] = '0; mg[i] = 0;
            mpfn0[i] = '0; mpfn1[i] = '0; mx0[i] = 0; mx1[i] = 0; mr0[i] = 0; mr1[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 and R12: empty after reset
        sweep("R1");
        look("R12", 20'h00003, 8'h00);
        check("R10", feat_word, 32'h2000_0000);

        // R2 R3 R11: fill every slot, globals at 0,5,10,15
        for (int i = 0; i < N; i++) begin
            stage(i, i * 3 + 1, i % 4, (i % 5) == 0, 0);
            step(1, 0, 0, 8'h00);
        end
        sweep("R2");
        look("R3", {mvpn2[7], 1'b0}, 8'h03);
        look("R3", {mvpn2[7], 1'b1}, 8'h02);
        look("R3", {mvpn2[10], 1'b1}, 8'h77);
        look("R11", {mvpn2[6], 1'b1}, 8'h02);

        // R9: duplicate of slot 3 written into slot 9
        stage(9, 3 * 3 + 1, 3, 0, 0);
        step(1, 0, 0, 8'h00);
        look("R9", {mvpn2[3], 1'b0}, 8'h03);
        check("R9", 32'(lk_idx), 32'd3);

        // R4: load slot 6 as invalid
        stage(6, 6 * 3 + 1, 2, 0, 1);
        step(1, 0, 0, 8'h00);
        look("R4", {19'(6 * 3 + 1), 1'b0}, 8'h02);
        check("R4", 32'(lk_hit), 32'd0);

        // R5 R6: clear identifier 1
        step(0, 1, 0, 8'h01);
        look("R5", {mvpn2[1], 1'b0}, 8'h01);
        check("R5", 32'(lk_hit), 32'd0);
        look("R6", {mvpn2[5], 1'b0}, 8'h01);
        check("R6", 32'(lk_hit), 32'd1);
        sweep("R6");

        // R8: write into slot 2 tagged 2 while clearing identifier 2
        stage(2, 100, 2, 0, 0);
        step(1, 1, 0, 8'h02);
        look("R8", {19'd100, 1'b1}, 8'h02);
        check("R8", 32'(lk_hit), 32'd1);
        sweep("R5");

        // R8 with flush, then R7 plain flush
        stage(4, 200, 3, 0, 0);
        step(1, 0, 1, 8'h00);
        look("R8", {19'd200, 1'b0}, 8'h03);
        check("R8", 32'(lk_hit), 32'd1);
        sweep("R7");
        step(0, 1, 1, 8'h09);
        look("R7", {19'd200, 1'b0}, 8'h03);
        check("R7", 32'(lk_hit), 32'd0);
        sweep("R7");
        look("R12", {19'd200, 1'b1}, 8'h03);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule